// File: doc/BRIEF.md
# Programmable Base Timer with Prescaler

The block is a 16-bit base timer that advances on a chosen count source. The source can be the internal system clock, divided by an even programmable ratio, or a pair of external phase pins decoded as quadrature. In quadrature mode the timer counts up or down depending on which phase leads. A run bit selects between two states. While it is clear, the counter is held at zero. While it is set, the counter is free to count.

Software writes a control byte and the run bit, and can load the counter directly. The block reports the live count and emits a one-cycle interrupt pulse on overflow. The overflow can be taken from the carry out of the top bit or from the carry out of the bit below it. Everything runs in the system clock domain: the prescaler produces single-cycle advance strobes and the phase pins are synchronised before decoding.

Control byte layout: bits [7:6] select the source, bits [5:1] hold the divide code n, and bit [0] selects the interrupt bit.

Top module: `base_tick_timer`

## Requirements
- R1: After reset, count_o is 0x0000, irq_o is 0, and the control byte is 0x00 (source stopped, n=0, top-bit interrupt).
- R2: While the run bit is 0, count_o is held at 0x0000 every cycle, and a counter write has no effect.
- R3: Source code 2'b00 (stop) and the reserved code 2'b01 leave the count unchanged. Code 2'b11 advances the count from the system clock through the prescaler.
- R4: Source code 2'b10 counts phase-pin edges only while two_phase_i is 1. While two_phase_i is 0 it behaves as stopped.
- R5: With source 2'b11 and divide code n from 0 to 30, the count advances once every 2(n+1) clock cycles. With n=31 it advances every cycle. The first advance comes 2(n+1) cycles after the run bit is set.
- R6: A counter write while running loads the written value, takes priority over an advance in the same cycle, and counting resumes from that value.
- R7: With interrupt select 0, irq_o pulses for one cycle when an up-count wraps 0xFFFF to 0x0000. An up-count from 0x7FFF raises no interrupt.
- R8: With interrupt select 1, irq_o pulses for one cycle on an up-count from any value whose low 15 bits are all ones, for example 0x7FFF to 0x8000.
- R9: In quadrature mode, each valid edge steps the count by one. The pin sequence (a,b) = 00,10,11,01 counts up, and the reverse sequence counts down. The prescaler is bypassed in this mode.
- R10: Writing a divide code that differs from the current one restarts the prescaler, so the next advance comes a full new period after the write.
- R11: irq_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_wr_i | input | 1 | Control byte write strobe |
| ctl_wdata_i | input | 8 | Control byte: [7:6] source, [5:1] divide code, [0] interrupt select |
| run_wr_i | input | 1 | Run bit write strobe |
| run_wdata_i | input | 1 | Run bit value |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 16 | Counter load value |
| two_phase_i | input | 1 | Two-phase processing mode enable |
| pha_i | input | 1 | Phase A pin (asynchronous) |
| phb_i | input | 1 | Phase B pin (asynchronous) |
| count_o | output | 16 | Current count |
| irq_o | output | 1 | One-cycle overflow interrupt |

## Verification
The assertions assume the phase pins change one at a time and no faster than the two-flop synchroniser can follow. The bench holds each pin level for four clock cycles and moves only one pin per step. They also assume that two_phase_i is changed only while no pin edge is in flight, and the bench changes it only with the pins at rest. The interrupt checks rely on a counter write suppressing any advance in the same cycle. The stimulus therefore loads values only at points where this priority is the intended behaviour.

// File: rtl/btmr_pkg.sv
package btmr_pkg;
  localparam int CNT_W = 16;
  localparam int DIV_W = 5;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'b00,
    SRC_RSV   = 2'b01,
    SRC_PHASE = 2'b10,
    SRC_SYS   = 2'b11
  } src_e;

  typedef struct packed {
    src_e             src;
    logic [DIV_W-1:0] div;
    logic             irq_sel;
  } ctl_t;
endpackage

// File: rtl/btmr_prescaler.sv
module btmr_prescaler #(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PRE_W = DIV_W + 1;
  localparam logic [DIV_W-1:0] BYPASS = {DIV_W{1'b1}};

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] lim;
  logic             bypass;

  assign lim    = {div_i, 1'b1};
  assign bypass = (div_i == BYPASS);
  assign tick_o = active_i && (bypass || (pre_q == lim));

  always_comb begin
    if (!active_i || clr_i || tick_o) pre_d = '0;
    else                              pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end
endmodule

// File: rtl/btmr_quad.sv
module btmr_quad (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pha_i,
  input  logic phb_i,
  output logic step_o,
  output logic up_o
);
  logic a_s1, a_s2, a_p;
  logic b_s1, b_s2, b_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_s1 <= 1'b0; a_s2 <= 1'b0; a_p <= 1'b0;
      b_s1 <= 1'b0; b_s2 <= 1'b0; b_p <= 1'b0;
    end else begin
      a_s1 <= pha_i; a_s2 <= a_s1; a_p <= a_s2;
      b_s1 <= phb_i; b_s2 <= b_s1; b_p <= b_s2;
    end
  end

  // exactly one phase moved: a valid quadrature edge
  assign step_o = en_i && ((a_s2 ^ a_p) ^ (b_s2 ^ b_p));
  assign up_o   = a_s2 ^ b_p;
endmodule

// File: rtl/btmr_counter.sv
module btmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             irq_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             carry_top, carry_sub;

  assign carry_top = &cnt_q;
  assign carry_sub = &cnt_q[CNT_W-2:0];

  always_comb begin
    if (!run_i)      cnt_d = '0;
    else if (wr_i)   cnt_d = wdata_i;
    else if (step_i) cnt_d = up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
    else             cnt_d = cnt_q;
    irq_d = run_i && !wr_i && step_i && up_i &&
            (irq_sel_i ? carry_sub : carry_top);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/base_tick_timer.sv
module base_tick_timer
  import btmr_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = DIV_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_wr_i,
  input  logic [DW+2:0] ctl_wdata_i,
  input  logic          run_wr_i,
  input  logic          run_wdata_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] cnt_wdata_i,
  input  logic          two_phase_i,
  input  logic          pha_i,
  input  logic          phb_i,
  output logic [CW-1:0] count_o,
  output logic          irq_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic [DW+2:0] ctl_q, ctl_d;
  logic          run_q, run_d;
  logic [1:0]    src;
  logic [DW-1:0] div_q, div_new;
  logic          irq_sel_q;
  logic          pre_active, pre_clr, pre_tick;
  logic          quad_en, quad_step, quad_up;
  logic          step, up;
  logic          src_halt;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign src       = ctl_q[DW+2:DW+1];
  assign div_q     = ctl_q[DW:1];
  assign irq_sel_q = ctl_q[0];
  assign div_new   = ctl_wdata_i[DW:1];

  always_comb begin
    ctl_d = ctl_wr_i ? ctl_wdata_i : ctl_q;
    run_d = run_wr_i ? run_wdata_i : run_q;
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ctl_q <= '0;
      run_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      run_q <= run_d;
    end
  end

  assign pre_active = run_q && (src == SRC_SYS);
  assign pre_clr    = ctl_wr_i && (div_new != div_q);
  assign quad_en    = run_q && (src == SRC_PHASE) && two_phase_i;
  assign src_halt   = !((src == SRC_SYS) || ((src == SRC_PHASE) && two_phase_i));

  btmr_prescaler #(.DIV_W(DW)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .active_i (pre_active),
    .clr_i    (pre_clr),
    .div_i    (div_q),
    .tick_o   (pre_tick)
  );

  btmr_quad u_quad (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .en_i   (quad_en),
    .pha_i  (pha_i),
    .phb_i  (phb_i),
    .step_o (quad_step),
    .up_o   (quad_up)
  );

  assign step = pre_tick | quad_step;
  assign up   = quad_step ? quad_up : 1'b1;

  btmr_counter #(.CNT_W(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .run_i     (run_q),
    .wr_i      (cnt_wr_i),
    .wdata_i   (cnt_wdata_i),
    .step_i    (step),
    .up_i      (up),
    .irq_sel_i (irq_sel_q),
    .cnt_o     (count_o),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/btmr_checker.sv
module btmr_checker #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] count_o,
  input logic          irq_o,
  input logic          cnt_wr_i,
  input logic          run_q,
  input logic          src_halt,
  input logic          irq_sel_q
);
  // R2: a cleared run bit forces zero on the next cycle
  p_hold_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> (count_o == '0));

  // R3 / R4: a halted source with no write leaves the count alone
  p_halt_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && src_halt && !cnt_wr_i) |=> $stable(count_o));

  // R5 / R9: without a write the count moves by at most one
  p_step_unit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !cnt_wr_i) |=> ((count_o == $past(count_o)) ||
                              (count_o == $past(count_o) + 1'b1) ||
                              (count_o == $past(count_o) - 1'b1)));

  // R7: top-bit interrupt coincides with a wrap to zero
  p_irq_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(irq_sel_q)) |-> (count_o == '0));

  // R8: any interrupt leaves the low bits cleared
  p_irq_carry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (count_o[CW-2:0] == '0));

  // R11: single-cycle pulse
  p_irq_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind base_tick_timer btmr_checker #(.CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .count_o   (count_o),
  .irq_o     (irq_o),
  .cnt_wr_i  (cnt_wr_i),
  .run_q     (run_q),
  .src_halt  (src_halt),
  .irq_sel_q (irq_sel_q)
);

// File: tb/base_tick_timer_tb_top.sv
`timescale 1ns/1ps
module base_tick_timer_tb_top;
  logic        clk, rst_n;
  logic        ctl_wr, run_wr, run_wd, cnt_wr, two_phase, pha, phb;
  logic [7:0]  ctl_wd;
  logic [15:0] cnt_wd, count;
  logic        irq;
  int          n_run, n_fail;
  bit          done;

  base_tick_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wd),
    .run_wr_i(run_wr), .run_wdata_i(run_wd), .cnt_wr_i(cnt_wr),
    .cnt_wdata_i(cnt_wd), .two_phase_i(two_phase), .pha_i(pha), .phb_i(phb),
    .count_o(count), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [4:0]  n;
    logic [7:0]  cyc;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{n: 5'd0,  cyc: 8'd10,  exp: 16'd5},
    '{n: 5'd1,  cyc: 8'd12,  exp: 16'd3},
    '{n: 5'd2,  cyc: 8'd13,  exp: 16'd2},
    '{n: 5'd4,  cyc: 8'd25,  exp: 16'd2},
    '{n: 5'd30, cyc: 8'd130, exp: 16'd2},
    '{n: 5'd31, cyc: 8'd7,   exp: 16'd7}
  };

  function automatic logic [7:0] mk(input logic [1:0] s, input logic [4:0] n,
                                    input logic sel);
    return {s, n, sel};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wd = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_run(input logic v);
    @(negedge clk); run_wr = 1'b1; run_wd = v;
    @(negedge clk); run_wr = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk); cnt_wr = 1'b1; cnt_wd = v;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic pins(input logic a, input logic b);
    @(negedge clk); pha = a; phb = b;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; ctl_wr = 0; ctl_wd = '0; run_wr = 0; run_wd = 0;
    cnt_wr = 0; cnt_wd = '0; two_phase = 0; pha = 0; phb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state; the stopped control byte keeps a running count at zero
    chk("R1 count", count, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    wr_run(1'b1);
    repeat (5) @(negedge clk);
    chk("R1 ctl stopped", count, 16'h0000);

    // R5: prescaler table
    for (int i = 0; i < 6; i++) begin
      wr_run(1'b0);
      wr_ctl(mk(2'b11, VEC[i].n, 1'b0));
      wr_run(1'b1);
      repeat (int'(VEC[i].cyc)) @(negedge clk);
      chk("R5 divide", count, VEC[i].exp);
    end

    // R2: held at zero, write ignored
    wr_run(1'b0);
    wr_ctl(mk(2'b11, 5'd31, 1'b0));
    repeat (3) @(negedge clk);
    chk("R2 held", count, 16'h0000);
    wr_cnt(16'h4321);
    chk("R2 write ignored", count, 16'h0000);

    // R3 / R6: load while stopped-source, stable, then count on
    wr_ctl(mk(2'b00, 5'd31, 1'b0));
    wr_run(1'b1);
    wr_cnt(16'h1234);
    chk("R6 load", count, 16'h1234);
    repeat (5) @(negedge clk);
    chk("R3 stop holds", count, 16'h1234);
    wr_ctl(mk(2'b01, 5'd31, 1'b0));
    repeat (5) @(negedge clk);
    chk("R3 reserved holds", count, 16'h1234);
    wr_ctl(mk(2'b11, 5'd31, 1'b0));
    repeat (3) @(negedge clk);
    chk("R6 continues", count, 16'h1237);

    // R7: top-bit wrap
    wr_ctl(mk(2'b00, 5'd31, 1'b0));
    wr_cnt(16'h7FFE);
    wr_ctl(mk(2'b11, 5'd31, 1'b0));
    @(negedge clk); @(negedge clk);
    chk("R7 no irq at 7FFF->8000", {15'd0, irq}, 16'h0000);
    wr_ctl(mk(2'b00, 5'd31, 1'b0));
    wr_cnt(16'hFFFE);
    wr_ctl(mk(2'b11, 5'd31, 1'b0));
    chk("R7 pre", count, 16'hFFFE);
    @(negedge clk);
    chk("R7 FFFF", count, 16'hFFFF);
    chk("R7 irq low", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    chk("R7 wrap", count, 16'h0000);
    chk("R7 irq pulse", {15'd0, irq}, 16'h0001);
    @(negedge clk);
    chk("R11 irq single", {15'd0, irq}, 16'h0000);

    // R8: sub-bit carry
    wr_ctl(mk(2'b00, 5'd31, 1'b1));
    wr_cnt(16'h7FFE);
    wr_ctl(mk(2'b11, 5'd31, 1'b1));
    @(negedge clk);
    chk("R8 irq low", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    chk("R8 count", count, 16'h8000);
    chk("R8 irq pulse", {15'd0, irq}, 16'h0001);
    @(negedge clk);
    chk("R11 irq single r8", {15'd0, irq}, 16'h0000);

    // R10: divide change restarts prescaler
    wr_run(1'b0);
    wr_ctl(mk(2'b11, 5'd3, 1'b0));
    wr_run(1'b1);
    repeat (5) @(negedge clk);
    wr_ctl(mk(2'b11, 5'd1, 1'b0));
    repeat (3) @(negedge clk);
    chk("R10 before", count, 16'h0000);
    @(negedge clk);
    chk("R10 restart", count, 16'h0001);

    // R4 / R9: quadrature
    wr_run(1'b0);
    wr_ctl(mk(2'b10, 5'd0, 1'b0));
    two_phase = 1'b1;
    wr_run(1'b1);
    pins(1, 0); pins(1, 1); pins(0, 1); pins(0, 0);
    chk("R9 up", count, 16'h0004);
    pins(0, 1); pins(1, 1); pins(1, 0);
    chk("R9 down", count, 16'h0001);
    @(negedge clk); two_phase = 1'b0;
    pins(0, 0); pins(0, 1);
    chk("R4 no mode stopped", count, 16'h0001);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule